// File: doc/BRIEF.md
# I2C Slave Transfer Engine

This block is a software-driven I2C slave. It watches the two bus lines, finds START and STOP conditions and reads the 8-bit header that follows each START. The header is a 7-bit address followed by a direction bit. The block answers its own address, and the all-zero broadcast address for writes. It then receives bytes from the master, or sends bytes to it, one byte per software handshake.

Every bus event of interest raises an interrupt flag and posts an 8-bit status code. While the block is still in the transfer, it holds SCL low until software clears the flag, which gives software unlimited time to read or supply data. Whether the block acknowledges an address or a data byte is decided by a software acknowledge-enable bit. Only slave operation with 7-bit addressing is built.

The bus is open-drain. The block only reads SCL and SDA, and it pulls a line low by asserting the matching `*_oe` output.

Top module: `i2c_slave_ctl`

## Requirements
- R1: After reset, `irq`, `scl_oe` and `sda_oe` are 0, the control register reads 0x00 and the status register reads 0xF8.
- R2: Writing 1s to offset 0 sets control bits. The bit positions are enable = 6, start-request = 5, stop-request = 4, interrupt flag = 3 and acknowledge-enable = 2. Writing 1s to offset 4 clears the same bits. Software can never set bit 3. Reading offset 0 returns the bits in these positions, with all other bits 0.
- R3: Offset 3 holds the own address in bits 6:0 and reads back with bit 7 as 0. Offset 2 is the data register. Writes to offset 1 have no effect.
- R4: While enabled with acknowledge-enable = 1, a header equal to the own address with direction 0 is acknowledged: SDA is held low in the ninth clock. The flag is then set with status 0x60, and SCL is held low until software clears the flag.
- R5: A header of 0x00 (broadcast address, write) is acknowledged in the same way, with status 0x70.
- R6: A header that matches neither address, the broadcast address with direction 1, or any header while acknowledge-enable = 0, gets no acknowledge and no flag. The block then ignores the bus until the next START.
- R7: In receive mode with acknowledge-enable = 1, each byte is acknowledged. The byte is placed in the data register and the flag is set with status 0x80, holding SCL low.
- R8: In receive mode with acknowledge-enable = 0 when a byte ends, that byte is not acknowledged. It is still placed in the data register, and the flag is set with status 0x88 without holding SCL. Further bytes are ignored until the next START.
- R9: A STOP or repeated START while the block is in a transfer sets the flag with status 0xA0, without holding SCL.
- R10: A header equal to the own address with direction 1 is acknowledged with status 0xA8 and SCL held. After the flag is cleared, the data register is driven onto SDA MSB first.
- R11: After a sent byte, a master acknowledge gives status 0xB8 with SCL held for the next byte. A master not-acknowledge gives status 0xC0 and releases both SDA and SCL.
- R12: Offset 1 reads the posted status code while the flag is set, and 0xF8 while it is clear. `irq` equals the flag.
- R13: While enable is 0, the block drives neither line and answers no header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (3) | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt flag |

## Verification
The bench targets several corner cases:
- **Near-miss and broadcast-read headers.** A design that compares too few address bits would acknowledge them.
- **Acknowledge-enable dropped between bytes.** A design that latched the bit at address time would keep acknowledging, and one that stretched on 0x88 would hang the master.
- **Repeated START in the middle of a transfer.** A design that treated it only as a new header would never post 0xA0.
- **A read that ends in a master not-acknowledge.** A design that kept SDA or SCL low there would wedge the bus.
- **Transmitted bytes sampled bit by bit.** This exposes LSB-first shifting or a one-bit skew at the first bit after the clock stretch.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  // control register bit positions
  localparam int CB_EN  = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam int CB_AA  = 2;

  // register offsets
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_DATA = 2;
  localparam int OFS_OWN  = 3;
  localparam int OFS_CLR  = 4;

  // status codes
  localparam logic [7:0] CODE_OWN_W   = 8'h60;
  localparam logic [7:0] CODE_BCAST_W = 8'h70;
  localparam logic [7:0] CODE_RX_ACK  = 8'h80;
  localparam logic [7:0] CODE_RX_NACK = 8'h88;
  localparam logic [7:0] CODE_END     = 8'hA0;
  localparam logic [7:0] CODE_OWN_R   = 8'hA8;
  localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
  localparam logic [7:0] CODE_TX_NACK = 8'hC0;
  localparam logic [7:0] CODE_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_R, ST_TX, ST_ACK_T, ST_STALL
  } slv_state_e;

  typedef enum logic [1:0] {
    HIT_NONE, HIT_OWN, HIT_BCAST
  } hit_e;

  // header = {address[6:0], direction}
  function automatic hit_e classify_hdr(input logic [7:0] hdr, input logic [6:0] own);
    if (hdr[7:1] == 7'd0) return hdr[0] ? HIT_NONE : HIT_BCAST;
    if (hdr[7:1] == own)  return HIT_OWN;
    return HIT_NONE;
  endfunction

  function automatic logic [7:0] status_view(input logic flag, input logic [7:0] code);
    return flag ? code : CODE_NONE;
  endfunction

  function automatic logic in_transfer(input slv_state_e s);
    return (s == ST_RX) || (s == ST_ACK_R) || (s == ST_TX) ||
           (s == ST_ACK_T) || (s == ST_STALL);
  endfunction

endpackage

// File: rtl/i2c_bus_mon.sv
module i2c_bus_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  // SDA edges count only while SCL is stable high
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_slave_regs.sv
module i2c_slave_regs
  import i2c_slv_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ev_valid,
  input  logic [7:0]        ev_code,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              en,
  output logic              aa,
  output logic              si,
  output logic [6:0]        own_addr,
  output logic [7:0]        tx_data
);

  localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFS_DATA);
  localparam logic [REG_AW-1:0] A_OWN  = REG_AW'(OFS_OWN);
  localparam logic [REG_AW-1:0] A_CLR  = REG_AW'(OFS_CLR);

  logic sta, sto;
  logic [7:0] stat_q, data_q;
  logic wr_set, wr_clr;

  assign wr_set = reg_wr && (reg_addr == A_CTRL);
  assign wr_clr = reg_wr && (reg_addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; aa <= 1'b0; sta <= 1'b0; sto <= 1'b0; si <= 1'b0;
    end else begin
      if (wr_set) begin
        en  <= en  | reg_wdata[CB_EN];
        sta <= sta | reg_wdata[CB_STA];
        sto <= sto | reg_wdata[CB_STO];
        aa  <= aa  | reg_wdata[CB_AA];
      end else if (wr_clr) begin
        en  <= en  & ~reg_wdata[CB_EN];
        sta <= sta & ~reg_wdata[CB_STA];
        sto <= sto & ~reg_wdata[CB_STO];
        aa  <= aa  & ~reg_wdata[CB_AA];
      end
      // bus events win over a software clear in the same cycle
      if (ev_valid)                    si <= 1'b1;
      else if (wr_clr && reg_wdata[CB_SI]) si <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q   <= CODE_NONE;
      data_q   <= 8'h00;
      own_addr <= 7'd0;
    end else begin
      if (ev_valid) stat_q <= ev_code;
      if (rx_valid) data_q <= rx_byte;
      else if (reg_wr && reg_addr == A_DATA) data_q <= reg_wdata;
      if (reg_wr && reg_addr == A_OWN) own_addr <= reg_wdata[6:0];
    end
  end

  assign tx_data = data_q;

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = {1'b0, en, sta, sto, si, aa, 2'b00};
      A_STAT:  reg_rdata = status_view(si, stat_q);
      A_DATA:  reg_rdata = data_q;
      A_OWN:   reg_rdata = {1'b0, own_addr};
      default: reg_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       aa,
  input  logic       si,
  input  logic [6:0] own_addr,
  input  logic [7:0] tx_data,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  output logic       ev_valid,
  output logic [7:0] ev_code,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       sda_oe,
  output logic       scl_oe
);

  slv_state_e st_q, st_d, ret_q, ret_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] sh_q, sh_d;
  logic       sda_q, sda_d;
  logic       ack_q, ack_d;
  hit_e       hit;

  assign hit = classify_hdr(sh_q, own_addr);

  always_comb begin
    st_d = st_q; ret_d = ret_q; cnt_d = cnt_q; sh_d = sh_q;
    sda_d = sda_q; ack_d = ack_q;
    ev_valid = 1'b0; ev_code = CODE_NONE; rx_valid = 1'b0;
    if (!en) begin
      st_d = ST_IDLE; sda_d = 1'b0; cnt_d = 4'd0;
    end else if (start_det) begin
      if (in_transfer(st_q)) begin ev_valid = 1'b1; ev_code = CODE_END; end
      st_d = ST_ADDR; cnt_d = 4'd0; sda_d = 1'b0;
    end else if (stop_det) begin
      if (in_transfer(st_q)) begin ev_valid = 1'b1; ev_code = CODE_END; end
      st_d = ST_IDLE; sda_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_s}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (hit != HIT_NONE && aa) begin sda_d = 1'b1; st_d = ST_ACK_A; end
            else st_d = ST_IDLE;
          end
        end
        ST_ACK_A: begin
          if (scl_fall) begin
            sda_d = 1'b0; st_d = ST_STALL; cnt_d = 4'd0; ev_valid = 1'b1;
            if (hit == HIT_BCAST) begin ev_code = CODE_BCAST_W; ret_d = ST_RX; end
            else if (sh_q[0])      begin ev_code = CODE_OWN_R;   ret_d = ST_TX; end
            else                   begin ev_code = CODE_OWN_W;   ret_d = ST_RX; end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_d = {sh_q[6:0], sda_s}; cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            sda_d = aa; ack_d = aa; st_d = ST_ACK_R;
          end
        end
        ST_ACK_R: begin
          if (scl_fall) begin
            sda_d = 1'b0; rx_valid = 1'b1; cnt_d = 4'd0; ev_valid = 1'b1;
            if (ack_q) begin ev_code = CODE_RX_ACK; st_d = ST_STALL; ret_d = ST_RX; end
            else       begin ev_code = CODE_RX_NACK; st_d = ST_IDLE; end
          end
        end
        ST_TX: begin
          if (scl_rise) cnt_d = cnt_q + 4'd1;
          else if (scl_fall) begin
            if (cnt_q == 4'd8) begin sda_d = 1'b0; st_d = ST_ACK_T; end
            else begin sh_d = {sh_q[6:0], 1'b0}; sda_d = ~sh_q[6]; end
          end
        end
        ST_ACK_T: begin
          if (scl_rise) ack_d = ~sda_s;
          else if (scl_fall) begin
            ev_valid = 1'b1; cnt_d = 4'd0;
            if (ack_q) begin ev_code = CODE_TX_ACK; st_d = ST_STALL; ret_d = ST_TX; end
            else       begin ev_code = CODE_TX_NACK; st_d = ST_IDLE; end
          end
        end
        ST_STALL: begin
          if (!si) begin
            st_d = ret_q; cnt_d = 4'd0;
            if (ret_q == ST_TX) begin sh_d = tx_data; sda_d = ~tx_data[7]; end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ret_q <= ST_IDLE; cnt_q <= 4'd0;
      sh_q <= 8'h00; sda_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_d; ret_q <= ret_d; cnt_q <= cnt_d;
      sh_q <= sh_d; sda_q <= sda_d; ack_q <= ack_d;
    end
  end

  assign rx_byte = sh_q;
  assign sda_oe  = sda_q;
  assign scl_oe  = (st_q == ST_STALL);

endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
  import i2c_slv_pkg::*;
#(
  parameter int REG_AW      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ev_valid, rx_valid;
  logic [7:0] ev_code, rx_byte, tx_data;
  logic ctrl_en, ctrl_aa, ctrl_si;
  logic [6:0] own_addr;

  i2c_bus_mon #(.SYNC_STAGES(SYNC_STAGES)) mon_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_regs #(.REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_code(ev_code), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .en(ctrl_en), .aa(ctrl_aa), .si(ctrl_si), .own_addr(own_addr), .tx_data(tx_data)
  );

  i2c_slave_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_en), .aa(ctrl_aa), .si(ctrl_si),
    .own_addr(own_addr), .tx_data(tx_data), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ev_valid(ev_valid), .ev_code(ev_code), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  assign irq = ctrl_si;

endmodule

// File: rtl/i2c_slave_chk.sv
module i2c_slave_chk #(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              ctrl_en,
  input logic              ev_valid,
  input logic [7:0]        ev_code,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_rdata
);

  // R12
  status_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == REG_AW'(1) && !irq) |-> (reg_rdata == 8'hF8));

  // R4
  stretch_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_oe && !irq) |-> $past(irq));

  // R4
  flag_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_valid));

  // R13
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !$past(ctrl_en)) |-> (!sda_oe && !scl_oe));

  // R9
  end_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == 8'hA0) |=> !scl_oe);

  // R8
  rx_nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == 8'h88) |=> (!sda_oe && !scl_oe));

  // R11
  tx_nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == 8'hC0) |=> (!sda_oe && !scl_oe));

endmodule

bind i2c_slave_ctl i2c_slave_chk #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .ctrl_en(ctrl_en), .ev_valid(ev_valid), .ev_code(ev_code),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/i2c_slave_ctl_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_ctl_tb_top;

  localparam int HP = 20;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic [6:0] own;
    logic       aa;
    logic [7:0] hdr;
    logic [7:0] dat;
    logic       hdr_ack;
    logic [7:0] code;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{7'h2A, 1'b1, 8'h54, 8'hA5, 1'b1, 8'h60},
    '{7'h2A, 1'b1, 8'h00, 8'h3C, 1'b1, 8'h70},
    '{7'h2A, 1'b1, 8'h56, 8'h11, 1'b0, 8'h00},
    '{7'h11, 1'b1, 8'h22, 8'hFF, 1'b1, 8'h60},
    '{7'h7F, 1'b1, 8'hFE, 8'h00, 1'b1, 8'h60},
    '{7'h2A, 1'b1, 8'h01, 8'h77, 1'b0, 8'h00},
    '{7'h2A, 1'b0, 8'h54, 8'h99, 1'b0, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic m_scl, m_sda;
  logic scl_oe, sda_oe, irq;
  logic scl_bus, sda_bus;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  assign scl_bus = m_scl & ~scl_oe;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_slave_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [7:0] act, input logic [7:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clr_flag();
    wr(3'd4, 8'h08);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(HP);
    m_scl = 1'b1; wait (scl_bus == 1'b1); cyc(HP);
    m_sda = 1'b0; cyc(HP);
    m_scl = 1'b0; cyc(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(HP);
    m_scl = 1'b1; wait (scl_bus == 1'b1); cyc(HP);
    m_sda = 1'b1; cyc(HP);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; cyc(HP);
    m_scl = 1'b1; wait (scl_bus == 1'b1); cyc(HP/2);
    s = sda_bus; cyc(HP/2);
    m_scl = 1'b0; cyc(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~give_ack, s);
  endtask

  initial begin
    repeat (WD_LIMIT) @(negedge clk);
    n_fail++;
    $display("FAIL all requirements: watchdog cycles=%0d expected < %0d", WD_LIMIT, WD_LIMIT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ack;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    m_scl = 1'b1; m_sda = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    chk_eq("R1 irq", {7'd0, irq}, 8'h00);
    chk_eq("R1 oe", {6'd0, scl_oe, sda_oe}, 8'h00);
    rd(3'd0, v); chk_eq("R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk_eq("R1 status", v, 8'hF8);

    // R2 set/clear, SI not settable
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk_eq("R2 set all", v, 8'h74);
    chk_eq("R2 irq stays 0", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h30);
    rd(3'd0, v); chk_eq("R2 clear sta/sto", v, 8'h44);

    // R3 own address, data, status write ignored
    wr(3'd3, 8'hAA);
    rd(3'd3, v); chk_eq("R3 own addr", v, 8'h2A);
    wr(3'd2, 8'h5C);
    rd(3'd2, v); chk_eq("R3 data", v, 8'h5C);
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk_eq("R3 status write ignored", v, 8'hF8);

    // vector table: write transfers (R4 R5 R6 R7 R9 R12)
    for (int i = 0; i < 7; i++) begin
      wr(3'd3, {1'b0, VECS[i].own});
      if (VECS[i].aa) wr(3'd0, 8'h44); else wr(3'd4, 8'h04);
      bus_start();
      send_byte(VECS[i].hdr, ack);
      chk_eq("R4/R5/R6 header ack", {7'd0, ack}, {7'd0, VECS[i].hdr_ack});
      if (VECS[i].hdr_ack) begin
        cyc(4);
        chk_eq("R4/R5 irq", {7'd0, irq}, 8'h01);
        rd(3'd1, v); chk_eq("R4/R5 status", v, VECS[i].code);
        chk_eq("R4 scl held", {7'd0, scl_oe}, 8'h01);
        clr_flag();
        cyc(3);
        chk_eq("R4 scl released", {7'd0, scl_oe}, 8'h00);
        rd(3'd1, v); chk_eq("R12 status idle", v, 8'hF8);
        send_byte(VECS[i].dat, ack);
        chk_eq("R7 data ack", {7'd0, ack}, 8'h01);
        rd(3'd1, v); chk_eq("R7 status", v, 8'h80);
        rd(3'd2, v); chk_eq("R7 data reg", v, VECS[i].dat);
        chk_eq("R7 scl held", {7'd0, scl_oe}, 8'h01);
        clr_flag();
        bus_stop();
        chk_eq("R9 stop irq", {7'd0, irq}, 8'h01);
        rd(3'd1, v); chk_eq("R9 stop status", v, 8'hA0);
        chk_eq("R9 no stretch", {7'd0, scl_oe}, 8'h00);
        clr_flag();
      end else begin
        chk_eq("R6 no flag", {7'd0, irq}, 8'h00);
        chk_eq("R6 sda free", {7'd0, sda_oe}, 8'h00);
        bus_stop();
        chk_eq("R6 no flag after stop", {7'd0, irq}, 8'h00);
      end
    end
    wr(3'd3, 8'h2A);
    wr(3'd0, 8'h44);

    // R8 acknowledge-enable dropped before a data byte
    bus_start();
    send_byte(8'h54, ack);
    chk_eq("R8 setup ack", {7'd0, ack}, 8'h01);
    wr(3'd4, 8'h0C);
    send_byte(8'h5A, ack);
    chk_eq("R8 data nack", {7'd0, ack}, 8'h00);
    rd(3'd1, v); chk_eq("R8 status", v, 8'h88);
    rd(3'd2, v); chk_eq("R8 data reg", v, 8'h5A);
    chk_eq("R8 no stretch", {6'd0, scl_oe, sda_oe}, 8'h00);
    clr_flag();
    wr(3'd0, 8'h04);
    send_byte(8'h33, ack);
    chk_eq("R8 later byte ignored ack", {7'd0, ack}, 8'h00);
    chk_eq("R8 later byte no flag", {7'd0, irq}, 8'h00);
    rd(3'd2, v); chk_eq("R8 data kept", v, 8'h5A);
    bus_stop();
    chk_eq("R8 stop not reported", {7'd0, irq}, 8'h00);

    // R9 repeated START during a write
    bus_start();
    send_byte(8'h54, ack);
    clr_flag();
    send_byte(8'h81, ack);
    chk_eq("R9 pre data ack", {7'd0, ack}, 8'h01);
    clr_flag();
    bus_start();
    chk_eq("R9 rstart irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk_eq("R9 rstart status", v, 8'hA0);
    chk_eq("R9 rstart no stretch", {7'd0, scl_oe}, 8'h00);
    clr_flag();
    send_byte(8'h54, ack);
    chk_eq("R9 readdressed", {7'd0, ack}, 8'h01);
    rd(3'd1, v); chk_eq("R9 readdressed status", v, 8'h60);
    clr_flag();
    bus_stop();
    clr_flag();

    // R10 R11 read transfer
    bus_start();
    send_byte(8'h55, ack);
    chk_eq("R10 read hdr ack", {7'd0, ack}, 8'h01);
    rd(3'd1, v); chk_eq("R10 status", v, 8'hA8);
    chk_eq("R10 scl held", {7'd0, scl_oe}, 8'h01);
    wr(3'd2, 8'hC6);
    clr_flag();
    recv_byte(1'b1, v);
    chk_eq("R10 byte msb first", v, 8'hC6);
    rd(3'd1, v); chk_eq("R11 ack status", v, 8'hB8);
    chk_eq("R11 scl held", {7'd0, scl_oe}, 8'h01);
    wr(3'd2, 8'h3B);
    clr_flag();
    recv_byte(1'b0, v);
    chk_eq("R10 second byte", v, 8'h3B);
    rd(3'd1, v); chk_eq("R11 nack status", v, 8'hC0);
    chk_eq("R11 bus released", {6'd0, scl_oe, sda_oe}, 8'h00);
    clr_flag();
    bus_stop();
    chk_eq("R11 stop after release", {7'd0, irq}, 8'h00);

    // R13 disabled
    wr(3'd4, 8'h40);
    bus_start();
    send_byte(8'h54, ack);
    chk_eq("R13 no ack", {7'd0, ack}, 8'h00);
    chk_eq("R13 no flag", {7'd0, irq}, 8'h00);
    bus_stop();
    chk_eq("R13 no flag after stop", {7'd0, irq}, 8'h00);
    wr(3'd0, 8'h40);
    bus_start();
    send_byte(8'h54, ack);
    chk_eq("R13 re-enabled ack", {7'd0, ack}, 8'h01);
    clr_flag();
    bus_stop();
    clr_flag();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule